// File: doc/BRIEF.md
# Dual-Issue In-Order Scoreboard

This block is the issue controller of a two-wide in-order pipeline that lets results complete out of order. Decoded instructions arrive as a pair. Each one carries a destination register, up to two source registers with enable bits, a unit class (integer or floating-point) and an execution latency. The pair sits in two decode slots. A new pair is taken only after both slots have drained.

Each cycle the block decides which slots may issue. It sends each issued operation to one of three execution units: two integer units and one floating-point unit. The units are modelled as latency counters, so no arithmetic is done here. A per-register countdown shows when each pending destination will be written. Issue stalls on a busy or already-claimed unit, on a read-after-write dependency, and on a write-after-write dependency where an older write would land at the same time as the new one or later. It also stalls when both write-back ports are already booked for the cycle in which the result would arrive.

Top module: `dis_scoreboard`

## Requirements
- R1: `in_ready` is high exactly when both decode slots are empty. A pair offered on `in_vld` while ready is captured at that clock edge (bit 0 is the older slot, bit 1 the younger). It can issue at the earliest in the next cycle.
- R2: The younger slot never issues ahead of the older one. While the older slot is occupied and stalled, the younger slot does not issue.
- R3: Unit indices 0 to NUM_INT-1 are integer units and index NUM_INT is the floating-point unit (0, 1 and 2 by default). An integer operation takes the lowest-numbered free integer unit. A unit is free when idle or in its own write-back cycle. An operation whose unit is busy, or has been taken by the older slot in the same cycle, stalls.
- R4: An operation whose enabled source is the destination of a pending write stalls until the cycle after that write-back. This includes the older slot of the same pair issuing in the same cycle.
- R5: An operation stalls while an older write to the same destination (in flight, or issuing from the older slot) would write back in the same cycle as the new operation or later.
- R6: An operation issued in cycle t with latency L (1 to MAX_LAT) appears on a write-back port with its destination register in cycle t+L, exactly once.
- R7: At most two results are written back per cycle. An operation whose write-back cycle already holds two results stalls. Simultaneous results are placed on ports in ascending unit order: the lowest unit goes to port 0.
- R8: After reset both slots are empty, `in_ready` is high, and no issue and no write-back is signalled.
- R9: A younger operation with a shorter latency writes back before an older operation with a longer latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 2 | Slot-valid mask of the offered pair (bit 0 older) |
| in_ready | output | 1 | Both decode slots empty |
| in_dst | input | 2 x REG_W | Destination register per slot |
| in_sa | input | 2 x REG_W | First source register per slot |
| in_sb | input | 2 x REG_W | Second source register per slot |
| in_sa_en | input | 2 | First source used |
| in_sb_en | input | 2 | Second source used |
| in_fp | input | 2 | 1 = floating-point class, 0 = integer |
| in_lat | input | 2 x LAT_W | Execution latency, 1 to MAX_LAT |
| iss | output | 2 | Slot issues in this cycle |
| iss_unit | output | 2 x UNIT_W | Unit taken by each issuing slot |
| wb_vld | output | 2 | Write-back port carries a result |
| wb_reg | output | 2 x REG_W | Register written on each port |

## Verification
Independent integer pairs show the base rate of two issues per cycle and how integer units are chosen. An in-pair read dependency and a floating-point pair show which stalls come from data and which from unit contention. Two same-destination pairs are run with the latencies reversed. One must stall and the other must not, which separates the write-after-write rule from a plain "destination pending" stall. A pair behind a blocked older slot confirms the in-order rule. A third result aimed at an already full write-back cycle tests the port booking. A long-then-short pair shows completion out of program order.

// File: rtl/dis_pkg.sv
package dis_pkg;
   // number of slots decoded together and of result ports per cycle
   localparam int SLOTS    = 2;
   localparam int WB_PORTS = 2;
endpackage

// File: rtl/dis_pair_buf.sv
module dis_pair_buf #(
   parameter int W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [dis_pkg::SLOTS-1:0]         in_vld,
   input  logic [dis_pkg::SLOTS-1:0][W-1:0]  in_word,
   input  logic [dis_pkg::SLOTS-1:0]         go,
   output logic [dis_pkg::SLOTS-1:0]         s_vld,
   output logic [dis_pkg::SLOTS-1:0][W-1:0]  s_word,
   output logic                          ready
);
   assign ready = (s_vld == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_vld  <= '0;
         s_word <= '0;
      end else if (ready) begin
         s_vld <= in_vld;
         if (|in_vld) s_word <= in_word;
      end else begin
         s_vld <= s_vld & ~go;
      end
   end

   for (genvar k = 0; k < dis_pkg::SLOTS; k++) begin : g_hold
      // a stalled slot keeps its contents until it issues
      p_slot_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (s_vld[k] && !go[k]) |=> (s_vld[k] && $stable(s_word[k])));
   end
endmodule

// File: rtl/dis_reg_table.sv
module dis_reg_table #(
   parameter int REG_W = 3,
   parameter int LAT_W = 3,
   localparam int NREG = 1 << REG_W
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [dis_pkg::SLOTS-1:0]             set,
   input  logic [dis_pkg::SLOTS-1:0][REG_W-1:0]  set_reg,
   input  logic [dis_pkg::SLOTS-1:0][LAT_W-1:0]  set_lat,
   output logic [NREG-1:0][LAT_W-1:0]            rcnt
);
   if (REG_W < 1 || LAT_W < 2) begin : g_bad_cfg
      $error("dis_reg_table: REG_W and LAT_W out of range");
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      // the younger slot wins when both write the same register
      always_ff @(posedge clk) begin
         if (!rst_n)
            rcnt[r] <= '0;
         else if (set[1] && set_reg[1] == REG_W'(r))
            rcnt[r] <= set_lat[1];
         else if (set[0] && set_reg[0] == REG_W'(r))
            rcnt[r] <= set_lat[0];
         else if (rcnt[r] != '0)
            rcnt[r] <= rcnt[r] - LAT_W'(1);
      end
   end
endmodule

// File: rtl/dis_unit_pool.sv
module dis_unit_pool #(
   parameter int NUM_UNIT = 3,
   parameter int UNIT_W   = 2,
   parameter int REG_W    = 3,
   parameter int LAT_W    = 3
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic [dis_pkg::SLOTS-1:0]                 go,
   input  logic [dis_pkg::SLOTS-1:0][UNIT_W-1:0]     unit,
   input  logic [dis_pkg::SLOTS-1:0][LAT_W-1:0]      lat,
   input  logic [dis_pkg::SLOTS-1:0][REG_W-1:0]      dst,
   output logic [NUM_UNIT-1:0][LAT_W-1:0]            ucnt,
   output logic [dis_pkg::WB_PORTS-1:0]              wb_vld,
   output logic [dis_pkg::WB_PORTS-1:0][REG_W-1:0]   wb_reg
);
   import dis_pkg::*;

   if (NUM_UNIT < 2 || (1 << UNIT_W) < NUM_UNIT) begin : g_bad_cfg
      $error("dis_unit_pool: unit index too narrow");
   end

   logic [NUM_UNIT-1:0][REG_W-1:0] udst;
   logic [NUM_UNIT-1:0]            done;

   for (genvar u = 0; u < NUM_UNIT; u++) begin : g_unit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ucnt[u] <= '0;
            udst[u] <= '0;
         end else if (go[0] && unit[0] == UNIT_W'(u)) begin
            ucnt[u] <= lat[0];
            udst[u] <= dst[0];
         end else if (go[1] && unit[1] == UNIT_W'(u)) begin
            ucnt[u] <= lat[1];
            udst[u] <= dst[1];
         end else if (ucnt[u] != '0) begin
            ucnt[u] <= ucnt[u] - LAT_W'(1);
         end
      end
      assign done[u] = (ucnt[u] == LAT_W'(1));

      p_unit_load0_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (go[0] && unit[0] == UNIT_W'(u)) |=> (ucnt[u] == $past(lat[0])));
      p_unit_load1_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (go[1] && unit[1] == UNIT_W'(u)) |=> (ucnt[u] == $past(lat[1])));
   end

   // finishing units fill the ports lowest index first
   always_comb begin
      int n;
      n      = 0;
      wb_vld = '0;
      wb_reg = '0;
      for (int u = 0; u < NUM_UNIT; u++) begin
         if (done[u]) begin
            if (n < WB_PORTS) begin
               wb_vld[n] = 1'b1;
               wb_reg[n] = udst[u];
            end
            n++;
         end
      end
   end

   p_wb_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(done) <= WB_PORTS);
endmodule

// File: rtl/dis_scoreboard.sv
module dis_scoreboard #(
   parameter int REG_W   = 3,
   parameter int MAX_LAT = 4,
   parameter int NUM_INT = 2,
   localparam int NREG     = 1 << REG_W,
   localparam int LAT_W    = $clog2(MAX_LAT + 2),
   localparam int NUM_UNIT = NUM_INT + 1,
   localparam int UNIT_W   = $clog2(NUM_UNIT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            in_vld,
   output logic                  in_ready,
   input  logic [1:0][REG_W-1:0] in_dst,
   input  logic [1:0][REG_W-1:0] in_sa,
   input  logic [1:0][REG_W-1:0] in_sb,
   input  logic [1:0]            in_sa_en,
   input  logic [1:0]            in_sb_en,
   input  logic [1:0]            in_fp,
   input  logic [1:0][LAT_W-1:0] in_lat,
   output logic [1:0]            iss,
   output logic [1:0][UNIT_W-1:0] iss_unit,
   output logic [1:0]            wb_vld,
   output logic [1:0][REG_W-1:0] wb_reg
);
   import dis_pkg::*;

   localparam int SW = 3 * REG_W + LAT_W + 3;
   localparam logic [UNIT_W-1:0] FP_UNIT = UNIT_W'(NUM_INT);

   if (REG_W < 1 || MAX_LAT < 1 || NUM_INT < 1) begin : g_bad_cfg
      $error("dis_scoreboard: parameter out of range");
   end

   logic [SLOTS-1:0][SW-1:0]     in_word, s_word;
   logic [SLOTS-1:0]             s_vld, s_sae, s_sbe, s_fp;
   logic [SLOTS-1:0][REG_W-1:0]  s_dst, s_sa, s_sb;
   logic [SLOTS-1:0][LAT_W-1:0]  s_lat;
   logic [NREG-1:0][LAT_W-1:0]   rcnt;
   logic [NUM_UNIT-1:0][LAT_W-1:0] ucnt;
   logic [NUM_UNIT-1:0]          ufree;
   logic [SLOTS-1:0]             go;
   logic [SLOTS-1:0][UNIT_W-1:0] u_sel;

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign in_word[k] = {in_fp[k], in_sb_en[k], in_sa_en[k], in_lat[k],
                           in_sb[k], in_sa[k], in_dst[k]};
      assign {s_fp[k], s_sbe[k], s_sae[k], s_lat[k], s_sb[k], s_sa[k], s_dst[k]} = s_word[k];
   end

   for (genvar u = 0; u < NUM_UNIT; u++) begin : g_free
      assign ufree[u] = (ucnt[u] <= LAT_W'(1));
   end

   dis_pair_buf #(.W(SW)) u_pair (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
      .go(go), .s_vld(s_vld), .s_word(s_word), .ready(in_ready));

   dis_reg_table #(.REG_W(REG_W), .LAT_W(LAT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .set(go), .set_reg(s_dst), .set_lat(s_lat),
      .rcnt(rcnt));

   dis_unit_pool #(.NUM_UNIT(NUM_UNIT), .UNIT_W(UNIT_W), .REG_W(REG_W),
                   .LAT_W(LAT_W)) u_units (
      .clk(clk), .rst_n(rst_n), .go(go), .unit(u_sel), .lat(s_lat),
      .dst(s_dst), .ucnt(ucnt), .wb_vld(wb_vld), .wb_reg(wb_reg));

   // hazard and resource check, older slot first
   always_comb begin
      logic              g0, taken, raw, waw, ok, blocked;
      logic [UNIT_W-1:0] u0, u;
      int                wbn;
      g0 = 1'b0;
      u0 = '0;
      go = '0;
      u_sel = '0;
      for (int k = 0; k < SLOTS; k++) begin
         taken = (k == 1) && g0;
         raw = (s_sae[k] && (rcnt[s_sa[k]] != '0 || (taken && s_sa[k] == s_dst[0]))) ||
               (s_sbe[k] && (rcnt[s_sb[k]] != '0 || (taken && s_sb[k] == s_dst[0])));
         waw = (rcnt[s_dst[k]] > s_lat[k]) ||
               (taken && s_dst[k] == s_dst[0] && s_lat[0] >= s_lat[k]);
         ok = 1'b0;
         u  = FP_UNIT;
         if (s_fp[k]) begin
            ok = ufree[NUM_INT] && !(taken && u0 == FP_UNIT);
         end else begin
            for (int i = 0; i < NUM_INT; i++) begin
               if (!ok && ufree[i] && !(taken && u0 == UNIT_W'(i))) begin
                  ok = 1'b1;
                  u  = UNIT_W'(i);
               end
            end
         end
         wbn = 0;
         for (int i = 0; i < NUM_UNIT; i++)
            if (ucnt[i] == s_lat[k] + LAT_W'(1)) wbn++;
         if (taken && s_lat[0] == s_lat[k]) wbn++;
         blocked = (k == 1) && s_vld[0] && !g0;
         go[k] = s_vld[k] && !blocked && ok && !raw && !waw && (wbn < WB_PORTS);
         u_sel[k] = u;
         if (k == 0) begin
            g0 = go[0];
            u0 = u;
         end
      end
   end

   assign iss      = go;
   assign iss_unit = u_sel;

   p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (iss == '0));
   p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_vld[0] && !iss[0]) |-> !iss[1]);
   for (genvar p = 0; p < WB_PORTS; p++) begin : g_wbchk
      p_wb_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
         wb_vld[p] |-> (rcnt[wb_reg[p]] != '0));
   end
endmodule

// File: tb/dis_scoreboard_test.sv
module dis_scoreboard_test;
   localparam int CLK_NS = 10;

   typedef struct packed {
      logic       v;
      logic [2:0] d, a, b;
      logic       ae, be, fp;
      logic [2:0] lat;
   } ins_t;

   typedef struct {
      int r;
      int c;
   } wb_exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] in_vld = '0;
   logic in_ready;
   logic [1:0][2:0] in_dst = '0, in_sa = '0, in_sb = '0, in_lat = '0;
   logic [1:0] in_sa_en = '0, in_sb_en = '0, in_fp = '0;
   logic [1:0] iss, wb_vld;
   logic [1:0][1:0] iss_unit;
   logic [1:0][2:0] wb_reg;

   int cyc = 0;
   int total = 0;
   int bad = 0;
   bit done = 0;
   int iss_c[2];
   int iss_u[2];
   wb_exp_t exp_q[$];

   dis_scoreboard uut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ready(in_ready),
      .in_dst(in_dst), .in_sa(in_sa), .in_sb(in_sb), .in_sa_en(in_sa_en),
      .in_sb_en(in_sb_en), .in_fp(in_fp), .in_lat(in_lat), .iss(iss),
      .iss_unit(iss_unit), .wb_vld(wb_vld), .wb_reg(wb_reg));

   always #(CLK_NS / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor: compares each write-back with the queue, logs issues
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int p = 0; p < 2; p++) begin
            if (wb_vld[p]) begin
               if (exp_q.size() == 0) begin
                  check(0, "R6", "unexpected write-back reg", int'(wb_reg[p]), -1);
               end else begin
                  wb_exp_t e;
                  e = exp_q.pop_front();
                  check(int'(wb_reg[p]) == e.r, "R6", "write-back reg", int'(wb_reg[p]), e.r);
                  check(cyc == e.c, "R6", "write-back cycle", cyc, e.c);
               end
            end
         end
         for (int k = 0; k < 2; k++) begin
            if (iss[k]) begin
               iss_c[k] = cyc;
               iss_u[k] = int'(iss_unit[k]);
            end
         end
      end
   end

   function automatic ins_t mk(input int d, input int a, input bit ae, input int b,
                               input bit be, input bit fp, input int lat);
      ins_t i;
      i.v = 1'b1; i.d = 3'(d); i.a = 3'(a); i.b = 3'(b);
      i.ae = ae; i.be = be; i.fp = fp; i.lat = 3'(lat);
      return i;
   endfunction

   task automatic push(input int r, input int c);
      wb_exp_t e;
      e.r = r;
      e.c = c;
      exp_q.push_back(e);
   endtask

   task automatic send(input ins_t i0, input ins_t i1, output int lc);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_vld   = {i1.v, i0.v};
      in_dst   = {i1.d, i0.d};
      in_sa    = {i1.a, i0.a};
      in_sb    = {i1.b, i0.b};
      in_sa_en = {i1.ae, i0.ae};
      in_sb_en = {i1.be, i0.be};
      in_fp    = {i1.fp, i0.fp};
      in_lat   = {i1.lat, i0.lat};
      lc = cyc;
      @(negedge clk);
      in_vld = '0;
   endtask

   task automatic start();
      iss_c[0] = -1; iss_c[1] = -1;
      iss_u[0] = -1; iss_u[1] = -1;
   endtask

   task automatic finish_case(input string req);
      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, req, "results still owed", exp_q.size(), 0);
   endtask

   initial begin
      int l, lb;
      ins_t nop;
      nop = '0;
      repeat (3) @(negedge clk);
      // R8: reset state
      check(in_ready == 1'b1, "R8", "ready in reset", int'(in_ready), 1);
      check(iss == 2'b00, "R8", "issue in reset", int'(iss), 0);
      check(wb_vld == 2'b00, "R8", "write-back in reset", int'(wb_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R8", "ready after reset", int'(in_ready), 1);

      // R3 R6: independent integer pair
      start();
      send(mk(1,0,0,0,0,0,1), mk(2,0,0,0,0,0,2), l);
      push(1, l + 2); push(2, l + 3);
      finish_case("R6");
      check(iss_c[0] == l + 1, "R6", "slot0 issue cycle", iss_c[0], l + 1);
      check(iss_c[1] == l + 1, "R6", "slot1 issue cycle", iss_c[1], l + 1);
      check(iss_u[0] == 0, "R3", "slot0 unit", iss_u[0], 0);
      check(iss_u[1] == 1, "R3", "slot1 unit", iss_u[1], 1);

      // R4 R1: younger reads older's destination
      start();
      send(mk(3,0,0,0,0,0,3), mk(4,3,1,0,0,0,1), l);
      @(negedge clk);
      check(in_ready == 1'b0, "R1", "ready while slot pending", int'(in_ready), 0);
      push(3, l + 4); push(4, l + 6);
      finish_case("R4");
      check(iss_c[0] == l + 1, "R4", "producer issue", iss_c[0], l + 1);
      check(iss_c[1] == l + 5, "R4", "consumer issue", iss_c[1], l + 5);
      check(iss_u[1] == 0, "R3", "consumer unit", iss_u[1], 0);

      // R5: older slow write then younger fast write, same register
      start();
      send(mk(5,0,0,0,0,1,4), mk(5,0,0,0,0,0,1), l);
      push(5, l + 5); push(5, l + 6);
      finish_case("R5");
      check(iss_c[1] == l + 5, "R5", "younger write waits", iss_c[1], l + 5);

      // R5: older fast write, younger slow write: no stall
      start();
      send(mk(6,0,0,0,0,0,1), mk(6,0,0,0,0,0,3), l);
      push(6, l + 2); push(6, l + 4);
      finish_case("R5");
      check(iss_c[1] == l + 1, "R5", "no stall when older finishes first", iss_c[1], l + 1);

      // R3: two floating-point operations share one unit
      start();
      send(mk(1,0,0,0,0,1,2), mk(2,0,0,0,0,1,1), l);
      push(1, l + 3); push(2, l + 4);
      finish_case("R3");
      check(iss_c[1] == l + 3, "R3", "fp unit conflict issue", iss_c[1], l + 3);
      check(iss_u[1] == 2, "R3", "fp unit index", iss_u[1], 2);

      // R2 R1: stalled older slot holds the younger one
      start();
      send(mk(7,0,0,0,0,0,4), nop, l);
      push(7, l + 5);
      send(mk(1,7,1,0,0,0,1), mk(2,0,0,0,0,0,1), lb);
      check(lb == l + 2, "R1", "next pair load cycle", lb, l + 2);
      push(1, l + 7); push(2, l + 7);
      finish_case("R2");
      check(iss_c[0] == l + 6, "R2", "older issue", iss_c[0], l + 6);
      check(iss_c[1] == l + 6, "R2", "younger held with older", iss_c[1], l + 6);

      // R7: a third result aimed at a full write-back cycle
      start();
      send(mk(1,0,0,0,0,1,3), mk(2,0,0,0,0,0,3), l);
      push(2, l + 4); push(1, l + 4);
      send(mk(3,0,0,0,0,0,1), nop, lb);
      push(3, l + 5);
      finish_case("R7");
      check(iss_c[0] == l + 4, "R7", "issue deferred past full cycle", iss_c[0], l + 4);
      check(iss_u[0] == 0, "R3", "unit reused in its write-back cycle", iss_u[0], 0);

      // R9: younger short op completes first
      start();
      send(mk(1,0,0,0,0,0,4), mk(2,0,0,0,0,0,1), l);
      push(2, l + 2); push(1, l + 5);
      finish_case("R9");
      check(iss_c[1] == l + 1, "R9", "both issue together", iss_c[1], l + 1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog run did not end actual=%0d expected=%0d", cyc, 5000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule